// File: doc/BRIEF.md
# Tag-Matching Mesh Processing Cell

This block is one replicable cell of a two-dimensional computing mesh. It has four neighbour ports (index 0 = north, 1 = east, 2 = south, 3 = west). Each port has an input channel and an output channel with a valid/ready handshake. Every word on a channel is 48 bits: a 16-bit tag in bits [47:32] and 32 data bits in [31:0]. The tag is split into a 4-bit kind [47:44], an 8-bit name [43:36] and a 4-bit process id [35:32]. The cell holds a resident local object (a search key, a search mask and a 32-bit value) and an instruction. It watches every word that arrives from its neighbours.

A word whose tag matches the resident key under the mask is taken in as the operand. The cell combines it with the local value in a word-wide boolean ALU. It then sends a freshly tagged result toward one of two continuation ports, chosen by a zero test. Any other word passes straight through to the opposite port. Pass-through and execution can happen in the same cycle. Each output port has its own single-entry transfer buffer. A chain of such cells, each loaded with one instruction, forms a pipeline with fixed instructions and streaming data.

The cell is configured through its ordinary ports, using words of three reserved kinds whose name field equals the cell's own name parameter.

Top module: `mesh_cell`

## Requirements
- R1: After reset, no output is valid, no input is accepted while its valid is low, and the cell holds neither a loaded value nor a loaded instruction. While either is missing, no word is treated as a match.
- R2: A word of kind 4'hD, 4'hE or 4'hF whose name equals CELL_NAME is consumed and produces no output.
  - Kind 4'hD loads the instruction from its data.
  - Kind 4'hE loads the search key from data[15:0] and the mask from data[31:16].
  - Kind 4'hF loads the local value.
  - A word of these kinds with any other name is forwarded like plain traffic.
- R3: A word that is neither configuration nor a match is forwarded unchanged to the opposite port (0 to 2, 1 to 3, and back). It is valid there in the cycle after it is accepted.
- R4: A word is a match when both the value and the instruction are loaded, its kind is below 4'hD, and ((tag XOR key) AND mask) is zero. Tag bits whose mask bit is 0 are ignored.
- R5: The instruction opcode in data[2:0] selects the result from the local value A and the operand B: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives NOT A, 4 gives A, 5 gives B, and 6 or 7 give A.
- R6: The result is sent one cycle after the match is accepted. It goes to the port in instruction bits [4:3] when the result is non-zero, and otherwise to the port in bits [6:5]. Its tag is {kind from bits [11:8], name from bits [19:12], process id of the operand}, and its data is the ALU result.
- R7: When instruction bit 7 is set, each result also replaces the local value, so that the next match uses it as A.
- R8: An output whose buffer is valid while its ready is low keeps its word stable. An input whose destination buffer is full and not draining is held off (ready low) until that buffer drains.
- R9: Only one configuration or match word is taken per cycle, the lowest-numbered port first. A match result takes priority over a pass-through word that targets the same output buffer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-port input word valid |
| in_word | input | 192 | Per-port input word, port p in bits [48p+47:48p] |
| in_ready | output | 4 | Per-port input accept |
| out_valid | output | 4 | Per-port transfer buffer valid |
| out_word | output | 192 | Per-port output word, port p in bits [48p+47:48p] |
| out_ready | input | 4 | Per-port downstream accept |

## Verification
A pass-through word or a match result is accepted on a clock edge and appears in the destination buffer right after that edge. Configuration words produce nothing at any output. The bench drives each word just after a falling edge and reads the combinational ready value 1 ns later. It then checks the output 1 ns after the rising edge that accepted the word, which is the one cycle the requirements give. Stall and arbitration checks hold the inputs across several edges and compare ready and the held output word at each falling edge, before the next acceptance can occur.

// File: rtl/cell_pkg.sv
package cell_pkg;
    localparam int NPORT   = 4;
    localparam int PORT_W  = $clog2(NPORT);
    localparam int DATA_W  = 32;
    localparam int KIND_W  = 4;
    localparam int NAME_W  = 8;
    localparam int PID_W   = 4;
    localparam int TAG_W   = KIND_W + NAME_W + PID_W;
    localparam int WORD_W  = TAG_W + DATA_W;
    localparam int OP_W    = 3;

    localparam logic [KIND_W-1:0] KIND_INSTR = 4'hD;
    localparam logic [KIND_W-1:0] KIND_KEY   = 4'hE;
    localparam logic [KIND_W-1:0] KIND_VALUE = 4'hF;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [NAME_W-1:0] name;
        logic [PID_W-1:0]  pid;
    } tag_t;

    typedef struct packed {
        tag_t              tag;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 3'd0,
        OP_OR    = 3'd1,
        OP_XOR   = 3'd2,
        OP_NOTA  = 3'd3,
        OP_PASSA = 3'd4,
        OP_PASSB = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic [11:0]       spare;
        logic [NAME_W-1:0] res_name;
        logic [KIND_W-1:0] res_kind;
        logic              write_back;
        logic [PORT_W-1:0] port_false;
        logic [PORT_W-1:0] port_true;
        logic [OP_W-1:0]   op;
    } instr_t;

    typedef struct packed {
        tag_t              key;
        logic [TAG_W-1:0]  mask;
        logic [DATA_W-1:0] value;
        logic              value_vld;
        instr_t            instr;
        logic              instr_vld;
    } cell_state_t;

    typedef struct packed {
        logic  vld;
        word_t word;
    } buf_state_t;
endpackage

// File: rtl/cell_tag_match.sv
module cell_tag_match
    import cell_pkg::*;
#(
    parameter logic [NAME_W-1:0] CELL_NAME = 8'h05
) (
    input  word_t            word,
    input  tag_t             key,
    input  logic [TAG_W-1:0] mask,
    input  logic             armed,
    output logic             is_cfg,
    output logic             is_hit
);
    logic reserved_kind;
    logic [TAG_W-1:0] diff;

    always_comb begin
        reserved_kind = (word.tag.kind >= KIND_INSTR);
        diff          = word.tag ^ key;
        is_cfg        = reserved_kind && (word.tag.name == CELL_NAME);
        is_hit        = armed && !reserved_kind && ((diff & mask) == '0);
    end
endmodule

// File: rtl/cell_alu.sv
module cell_alu
    import cell_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (alu_op_e'(op))
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_NOTA:  y = ~a;
            OP_PASSB: y = b;
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/cell_xfer_buf.sv
module cell_xfer_buf
    import cell_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wr_word,
    input  logic  rd_ready,
    output logic  vld,
    output word_t word,
    output logic  free
);
    buf_state_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (wr_en) begin
            buf_d.vld  = 1'b1;
            buf_d.word = wr_word;
        end else if (rd_ready) begin
            buf_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign vld  = buf_q.vld;
    assign word = buf_q.word;
    assign free = !buf_q.vld || rd_ready;
endmodule

// File: rtl/mesh_cell.sv
module mesh_cell
    import cell_pkg::*;
#(
    parameter logic [NAME_W-1:0] CELL_NAME = 8'h05
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*WORD_W-1:0] in_word,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*WORD_W-1:0] out_word,
    input  logic [NPORT-1:0]        out_ready
);
    localparam int HALF = NPORT / 2;

    cell_state_t st_d, st_q;

    word_t              in_w   [NPORT];
    word_t              buf_wd [NPORT];
    word_t              buf_q  [NPORT];
    logic [NPORT-1:0]   is_cfg, is_hit, buf_free, buf_vld, buf_wr, claim;
    logic               armed;
    logic               gnt_any;
    logic [PORT_W-1:0]  gnt_idx;
    word_t              op_word;
    logic [DATA_W-1:0]  alu_y;
    logic [PORT_W-1:0]  dest;
    word_t              res_word;

    assign armed = st_q.value_vld && st_q.instr_vld;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign in_w[p] = in_word[p*WORD_W +: WORD_W];

        cell_tag_match #(.CELL_NAME(CELL_NAME)) u_match (
            .word   (in_w[p]),
            .key    (st_q.key),
            .mask   (st_q.mask),
            .armed  (armed),
            .is_cfg (is_cfg[p]),
            .is_hit (is_hit[p])
        );

        cell_xfer_buf u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (buf_wr[p]),
            .wr_word  (buf_wd[p]),
            .rd_ready (out_ready[p]),
            .vld      (buf_vld[p]),
            .word     (buf_q[p]),
            .free     (buf_free[p])
        );

        assign out_valid[p]                  = buf_vld[p];
        assign out_word[p*WORD_W +: WORD_W]  = buf_q[p];
    end

    // Fixed-priority pick of one configuration or match word per cycle
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (in_valid[i] && (is_cfg[i] || is_hit[i])) begin
                gnt_any = 1'b1;
                gnt_idx = PORT_W'(i);
            end
        end
        op_word = in_w[gnt_idx];
    end

    cell_alu u_alu (
        .op (st_q.instr.op),
        .a  (st_q.value),
        .b  (op_word.data),
        .y  (alu_y)
    );

    always_comb begin
        dest              = (alu_y != '0) ? st_q.instr.port_true : st_q.instr.port_false;
        res_word.tag.kind = st_q.instr.res_kind;
        res_word.tag.name = st_q.instr.res_name;
        res_word.tag.pid  = op_word.tag.pid;
        res_word.data     = alu_y;
    end

    always_comb begin
        st_d     = st_q;
        in_ready = '0;
        buf_wr   = '0;
        claim    = '0;
        for (int i = 0; i < NPORT; i++) begin
            buf_wd[i] = '0;
        end

        if (gnt_any) begin
            if (is_cfg[gnt_idx]) begin
                in_ready[gnt_idx] = 1'b1;
                case (op_word.tag.kind)
                    KIND_INSTR: begin
                        st_d.instr     = instr_t'(op_word.data);
                        st_d.instr_vld = 1'b1;
                    end
                    KIND_KEY: begin
                        st_d.key  = tag_t'(op_word.data[TAG_W-1:0]);
                        st_d.mask = op_word.data[2*TAG_W-1:TAG_W];
                    end
                    default: begin
                        st_d.value     = op_word.data;
                        st_d.value_vld = 1'b1;
                    end
                endcase
            end else if (buf_free[dest]) begin
                in_ready[gnt_idx] = 1'b1;
                buf_wr[dest]      = 1'b1;
                buf_wd[dest]      = res_word;
                claim[dest]       = 1'b1;
                if (st_q.instr.write_back) begin
                    st_d.value = alu_y;
                end
            end
        end

        for (int i = 0; i < NPORT; i++) begin
            if (in_valid[i] && !is_cfg[i] && !is_hit[i]) begin
                if (buf_free[(i + HALF) % NPORT] && !claim[(i + HALF) % NPORT]) begin
                    in_ready[i]                  = 1'b1;
                    buf_wr[(i + HALF) % NPORT]   = 1'b1;
                    buf_wd[(i + HALF) % NPORT]   = in_w[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask      <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mesh_cell_chk.sv
module mesh_cell_chk
    import cell_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        in_valid,
    input logic [NPORT*WORD_W-1:0] in_word,
    input logic [NPORT-1:0]        in_ready,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT*WORD_W-1:0] out_word,
    input logic [NPORT-1:0]        out_ready,
    input logic                    armed
);
    localparam int HALF = NPORT / 2;

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_valid == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        localparam int OPP = (p + HALF) % NPORT;

        p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] && !out_ready[p]
            |=> out_valid[p] && $stable(out_word[p*WORD_W +: WORD_W]));

        p_no_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready[p] |-> in_valid[p]);

        p_pass_opposite_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !armed && in_valid[p] && in_ready[p]
            && (in_word[p*WORD_W + WORD_W - 1 -: KIND_W] < KIND_INSTR)
            |=> out_valid[OPP]
            && (out_word[OPP*WORD_W +: WORD_W] == $past(in_word[p*WORD_W +: WORD_W])));

        p_out_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_valid[p]) |-> $past(|(in_valid & in_ready)));
    end
endmodule

bind mesh_cell mesh_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ready (out_ready),
    .armed     (armed)
);

// File: tb/mesh_cell_bench.sv
`timescale 1ns/1ps
module mesh_cell_bench;
    import cell_pkg::*;

    localparam logic [7:0] ME = 8'h05;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NPORT-1:0]        in_valid = '0;
    logic [NPORT*WORD_W-1:0] in_word = '0;
    logic [NPORT-1:0]        in_ready;
    logic [NPORT-1:0]        out_valid;
    logic [NPORT*WORD_W-1:0] out_word;
    logic [NPORT-1:0]        out_ready = '1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    mesh_cell #(.CELL_NAME(ME)) u_mesh_cell (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
        .out_ready(out_ready)
    );

    always #10 clk = ~clk;

    function automatic logic [47:0] mk(input logic [3:0] k, input logic [7:0] n,
                                       input logic [3:0] pid, input logic [31:0] d);
        return {k, n, pid, d};
    endfunction

    function automatic logic [31:0] mk_instr(input logic [2:0] op, input logic [1:0] tp,
            input logic [1:0] fp, input logic wb, input logic [3:0] rk, input logic [7:0] rn);
        return {12'h0, rn, rk, wb, fp, tp, op};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return ~a;
            3'd5: return b;
            default: return a;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input int p, input logic [47:0] w);
        @(negedge clk);
        in_valid[p] = 1'b1;
        in_word[p*48 +: 48] = w;
        #1;
        while (!in_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid[p] = 1'b0;
    endtask

    task automatic expect_out(input string req, input int o, input logic [47:0] w);
        check(req, {63'h0, out_valid[o]}, 64'h1);
        check(req, {16'h0, out_word[o*48 +: 48]}, {16'h0, w});
    endtask

    task automatic cfg(input logic [3:0] k, input logic [31:0] d);
        send(0, mk(k, ME, 4'h0, d));
        check("R2 config consumed", {60'h0, out_valid}, 64'h0);
    endtask

    task automatic t_reset;
        check("R1 no output after reset", {60'h0, out_valid}, 64'h0);
        check("R1 no ready without valid", {60'h0, in_ready}, 64'h0);
        // would match the key loaded later; cell not armed so it passes
        send(0, mk(4'h1, 8'h20, 4'h7, 32'h0F0F_0F0F));
        expect_out("R1 unarmed word forwarded (R3)", 2, mk(4'h1, 8'h20, 4'h7, 32'h0F0F_0F0F));
    endtask

    task automatic t_config;
        cfg(KIND_KEY, {16'hFFF0, 4'h1, 8'h20, 4'h0});
        cfg(KIND_VALUE, 32'hF0F0_00FF);
        cfg(KIND_INSTR, mk_instr(3'd0, 2'd1, 2'd3, 1'b0, 4'h2, 8'h30));
        send(0, mk(KIND_INSTR, 8'h09, 4'h0, 32'hDEAD_0001));
        expect_out("R2 foreign config forwarded", 2, mk(KIND_INSTR, 8'h09, 4'h0, 32'hDEAD_0001));
    endtask

    task automatic t_match;
        send(0, mk(4'h1, 8'h20, 4'h7, 32'h0F0F_0F0F));
        expect_out("R6 nonzero result to true port", 1, mk(4'h2, 8'h30, 4'h7, 32'h0000_000F));
        send(2, mk(4'h1, 8'h20, 4'h3, 32'h0F0F_FF00));
        expect_out("R6 zero result to false port", 3, mk(4'h2, 8'h30, 4'h3, 32'h0));
        send(1, mk(4'h1, 8'h21, 4'h7, 32'h1111_2222));
        expect_out("R4 name mismatch passes", 3, mk(4'h1, 8'h21, 4'h7, 32'h1111_2222));
        send(3, mk(4'h3, 8'h20, 4'h0, 32'h3333_4444));
        expect_out("R4 kind mismatch passes", 1, mk(4'h3, 8'h20, 4'h0, 32'h3333_4444));
    endtask

    task automatic t_ops;
        for (int op = 0; op < 8; op++) begin
            cfg(KIND_INSTR, mk_instr(3'(op), 2'd1, 2'd1, 1'b0, 4'h2, 8'h30));
            send(0, mk(4'h1, 8'h20, 4'h5, 32'h1234_5678));
            expect_out($sformatf("R5 opcode %0d", op), 1,
                       mk(4'h2, 8'h30, 4'h5, ref_alu(3'(op), 32'hF0F0_00FF, 32'h1234_5678)));
        end
    endtask

    task automatic t_writeback;
        cfg(KIND_VALUE, 32'h0);
        cfg(KIND_INSTR, mk_instr(3'd2, 2'd1, 2'd3, 1'b1, 4'h2, 8'h30));
        send(0, mk(4'h1, 8'h20, 4'h1, 32'h0000_00FF));
        expect_out("R7 first accumulate", 1, mk(4'h2, 8'h30, 4'h1, 32'h0000_00FF));
        send(0, mk(4'h1, 8'h20, 4'h1, 32'h0000_00FF));
        expect_out("R7 local updated by writeback", 3, mk(4'h2, 8'h30, 4'h1, 32'h0));
    endtask

    task automatic t_backpressure;
        logic [47:0] wa, wb;
        wa = mk(4'h1, 8'h77, 4'h0, 32'hAAAA_0001);
        wb = mk(4'h1, 8'h77, 4'h0, 32'hBBBB_0002);
        @(negedge clk);
        out_ready[2] = 1'b0;
        send(0, wa);
        expect_out("R8 first word buffered", 2, wa);
        @(negedge clk);
        in_valid[0] = 1'b1;
        in_word[0 +: 48] = wb;
        #1;
        check("R8 input held off", {63'h0, in_ready[0]}, 64'h0);
        repeat (3) @(negedge clk);
        #1;
        check("R8 stalled word stable", {16'h0, out_word[2*48 +: 48]}, {16'h0, wa});
        check("R8 still held off", {63'h0, in_ready[0]}, 64'h0);
        out_ready[2] = 1'b1;
        #1;
        check("R8 accepted once draining", {63'h0, in_ready[0]}, 64'h1);
        @(posedge clk);
        #1;
        in_valid[0] = 1'b0;
        expect_out("R8 second word after drain", 2, wb);
        @(posedge clk);
        #1;
        check("R8 buffer empties", {63'h0, out_valid[2]}, 64'h0);
    endtask

    task automatic t_priority;
        logic [47:0] w2, w3, w0, wp;
        cfg(KIND_INSTR, mk_instr(3'd5, 2'd1, 2'd1, 1'b0, 4'h6, 8'h40));
        w2 = mk(4'h1, 8'h20, 4'h2, 32'h0000_2222);
        w3 = mk(4'h1, 8'h20, 4'h3, 32'h0000_3333);
        @(negedge clk);
        in_valid[2] = 1'b1; in_word[2*48 +: 48] = w2;
        in_valid[3] = 1'b1; in_word[3*48 +: 48] = w3;
        #1;
        check("R9 lowest port granted", {60'h0, in_ready}, 64'h4);
        @(posedge clk);
        #1;
        in_valid[2] = 1'b0;
        expect_out("R9 port 2 served first", 1, mk(4'h6, 8'h40, 4'h2, 32'h0000_2222));
        #1;
        check("R9 port 3 next", {60'h0, in_ready}, 64'h8);
        @(posedge clk);
        #1;
        in_valid[3] = 1'b0;
        expect_out("R9 port 3 served second", 1, mk(4'h6, 8'h40, 4'h3, 32'h0000_3333));
        w0 = mk(4'h1, 8'h20, 4'h4, 32'h0000_0444);
        wp = mk(4'h1, 8'h77, 4'h9, 32'h0000_0999);
        @(negedge clk);
        in_valid[0] = 1'b1; in_word[0 +: 48] = w0;
        in_valid[3] = 1'b1; in_word[3*48 +: 48] = wp;
        #1;
        check("R9 result beats pass-through", {60'h0, in_ready}, 64'h1);
        @(posedge clk);
        #1;
        in_valid[0] = 1'b0;
        expect_out("R9 result written", 1, mk(4'h6, 8'h40, 4'h4, 32'h0000_0444));
        #1;
        check("R9 pass-through follows", {60'h0, in_ready}, 64'h8);
        @(posedge clk);
        #1;
        in_valid[3] = 1'b0;
        expect_out("R9 pass-through written (R3)", 1, wp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_match();
        t_ops();
        t_writeback();
        t_backpressure();
        t_priority();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule